// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core that runs each instruction over several clock cycles and supports a six-instruction subset. The subset is load word, store word, register add, branch on equal, branch on not-equal, and load upper immediate. The core holds the fetch address in a program counter. It latches the fetched word into an instruction register and captures load data in a memory-data register. A 32-entry register file supplies every operand that does not come from an immediate field. A single ALU forms sums, compare differences and load/store effective addresses.

The core talks to an instruction port and a data port. Both use a request/ready handshake, so a cache in front of memory can stall the core for as many cycles as it needs. The core raises one request at a time. After every completed instruction it pulses a retire strobe for one cycle, together with a class code, so the surrounding system can count work by type.

Top module: `mc_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the core requests an instruction from byte address 0. The data port is idle and the retire strobe is low.
- R2: A fetch request keeps its address stable until ready is sampled high. The PC then advances by 4, and fetches follow program order.
- R3: Load word (opcode bits 31..26 = 100011) reads the data word at register rs plus the sign-extended 16-bit offset in bits 15..0. It writes that word into register rt (bits 20..16).
- R4: Store word (opcode 101011) writes register rt to the address register rs plus the sign-extended offset. It changes no register.
- R5: Add (opcode 000000 with function bits 5..0 = 100000 and shift bits 10..6 = 0) writes rs + rt into register rd (bits 15..11).
- R6: Branch-equal (opcode 000100) and branch-not-equal (opcode 000101) compare rs with rt. A taken branch sets the PC to PC+4 plus the sign-extended offset shifted left by 2. A branch that is not taken sets the PC to PC+4. Negative offsets branch backwards.
- R7: Load upper immediate (opcode 001111) writes the 16-bit immediate into bits 31..16 of rt and clears bits 15..0.
- R8: Register 0 always reads as zero, and a write to it has no effect.
- R9: A data request keeps its address, write enable and write data stable until ready is sampled high.
- R10: Each completed instruction raises the retire strobe for exactly one cycle. The class code is 00 for add, branch and load-upper-immediate, 01 for load, and 10 for store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| imem_req_o | output | 1 | Instruction fetch request |
| imem_addr_o | output | 32 | Fetch byte address (PC) |
| imem_rdy_i | input | 1 | Fetch data valid / request accepted |
| imem_rdata_i | input | 32 | Fetched instruction word |
| dmem_req_o | output | 1 | Data access request |
| dmem_we_o | output | 1 | Data access is a write |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_wdata_o | output | 32 | Store data |
| dmem_rdy_i | input | 1 | Data access complete |
| dmem_rdata_i | input | 32 | Load data |
| retire_o | output | 1 | One-cycle pulse per completed instruction |
| retire_cls_o | output | 2 | Class of the completed instruction |

## Verification
The timing of each result depends on handshakes, so the bench records each one at the clock edge where it becomes due. A fetch is recorded at the falling edge where ready is granted, and the PC moves at the next rising edge. A retire pulse appears one cycle after the last state of its instruction, and the bench logs it on the falling edge after that. Memory stores are captured on the falling edge where the data port grants ready. Each access has a wait of 0 to 3 cycles that depends on its address. Register and memory contents are checked only after the sixteenth retire pulse, and the fetch and retire order are compared entry by entry against an expected execution trace.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_BNE   = 6'b000101;
  localparam logic [5:0] OP_LUI   = 6'b001111;
  localparam logic [5:0] FN_ADD   = 6'b100000;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB
  } state_e;

  typedef enum logic [1:0] {
    ALU_ADD, ALU_SUB, ALU_PASSB
  } alu_op_e;

  typedef enum logic [1:0] {
    RC_ALU = 2'b00, RC_LOAD = 2'b01, RC_STORE = 2'b10
  } rclass_e;
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   ra_a_i,
  input  logic [AW-1:0]   ra_b_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o,
  input  logic            we_i,
  input  logic [AW-1:0]   wa_i,
  input  logic [XLEN-1:0] wd_i
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      regs[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = regs[ra_a_i];
  assign rd_b_o = regs[ra_b_i];

  // entry 0 must never pick up a write
  assert_r0_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && wa_i == '0 |=> regs[0] == '0);
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  always_comb begin
    unique case (op_i)
      ALU_SUB:   y_o = a_i - b_i;
      ALU_PASSB: y_o = b_i;
      default:   y_o = a_i + b_i;
    endcase
  end

  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG),
  localparam int IMW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic            imem_req_o,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic            imem_rdy_i,
  input  logic [XLEN-1:0] imem_rdata_i,
  output logic            dmem_req_o,
  output logic            dmem_we_o,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic            dmem_rdy_i,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic            retire_o,
  output logic [1:0]      retire_cls_o
);
  state_e          state_q;
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_q;
  logic            retire_q;
  rclass_e         rcls_q;

  // instruction fields
  logic [5:0]      op, fn;
  logic [AW-1:0]   rs, rt, rd;
  logic [4:0]      shamt;
  logic [IMW-1:0]  imm;
  logic [XLEN-1:0] sext;
  assign op    = ir_q[31:26];
  assign rs    = ir_q[21 +: AW];
  assign rt    = ir_q[16 +: AW];
  assign rd    = ir_q[11 +: AW];
  assign shamt = ir_q[10:6];
  assign fn    = ir_q[5:0];
  assign imm   = ir_q[15:0];
  assign sext  = {{(XLEN-IMW){imm[IMW-1]}}, imm};

  logic is_lw, is_sw, is_add, is_beq, is_bne, is_lui;
  assign is_lw  = (op == OP_LW);
  assign is_sw  = (op == OP_SW);
  assign is_add = (op == OP_RTYPE) && (fn == FN_ADD) && (shamt == '0);
  assign is_beq = (op == OP_BEQ);
  assign is_bne = (op == OP_BNE);
  assign is_lui = (op == OP_LUI);

  // register file
  logic [XLEN-1:0] rf_a, rf_b, rf_wd;
  logic            rf_we;
  logic [AW-1:0]   rf_wa;
  assign rf_we = (state_q == S_WB);
  assign rf_wa = (is_lw || is_lui) ? rt : rd;
  assign rf_wd = is_lw ? mdr_q : alu_q;

  mc_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_a_i(rs), .ra_b_i(rt), .rd_a_o(rf_a), .rd_b_o(rf_b),
    .we_i(rf_we), .wa_i(rf_wa), .wd_i(rf_wd)
  );

  // ALU operand selection
  alu_op_e         alu_op;
  logic [XLEN-1:0] alu_b, alu_y;
  logic            alu_zero;
  always_comb begin
    alu_op = ALU_ADD;
    alu_b  = b_q;
    if (is_lw || is_sw) alu_b = sext;
    if (is_beq || is_bne) alu_op = ALU_SUB;
    if (is_lui) begin
      alu_op = ALU_PASSB;
      alu_b  = {imm, {(XLEN-IMW){1'b0}}};
    end
  end

  mc_alu #(.XLEN(XLEN)) u_alu (
    .op_i(alu_op), .a_i(a_q), .b_i(alu_b), .y_o(alu_y), .zero_o(alu_zero)
  );

  logic            br_taken;
  logic [XLEN-1:0] br_target;
  assign br_taken  = (is_beq && alu_zero) || (is_bne && !alu_zero);
  assign br_target = pc_q + {sext[XLEN-3:0], 2'b00}; // pc_q already holds PC+4

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_FETCH;
      pc_q     <= '0;
      ir_q     <= '0;
      mdr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      alu_q    <= '0;
      retire_q <= 1'b0;
      rcls_q   <= RC_ALU;
    end else begin
      retire_q <= 1'b0;
      unique case (state_q)
        S_FETCH: if (imem_rdy_i) begin
          ir_q    <= imem_rdata_i;
          pc_q    <= pc_q + XLEN'(4);
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          a_q     <= rf_a;
          b_q     <= rf_b;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          alu_q <= alu_y;
          if (is_lw || is_sw) begin
            state_q <= S_MEM;
          end else if (is_add || is_lui) begin
            state_q <= S_WB;
          end else if (is_beq || is_bne) begin
            if (br_taken) pc_q <= br_target;
            retire_q <= 1'b1;
            rcls_q   <= RC_ALU;
            state_q  <= S_FETCH;
          end else begin
            state_q <= S_FETCH; // unsupported encoding: no effect
          end
        end
        S_MEM: if (dmem_rdy_i) begin
          if (is_lw) begin
            mdr_q   <= dmem_rdata_i;
            state_q <= S_WB;
          end else begin
            retire_q <= 1'b1;
            rcls_q   <= RC_STORE;
            state_q  <= S_FETCH;
          end
        end
        default: begin // S_WB
          retire_q <= 1'b1;
          rcls_q   <= is_lw ? RC_LOAD : RC_ALU;
          state_q  <= S_FETCH;
        end
      endcase
    end
  end

  assign imem_req_o   = (state_q == S_FETCH);
  assign imem_addr_o  = pc_q;
  assign dmem_req_o   = (state_q == S_MEM);
  assign dmem_we_o    = is_sw;
  assign dmem_addr_o  = alu_q;
  assign dmem_wdata_o = b_q;
  assign retire_o     = retire_q;
  assign retire_cls_o = rcls_q;

  assert_imem_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o && !imem_rdy_i |=> imem_req_o && $stable(imem_addr_o));
  assert_pc_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imem_req_o && imem_rdy_i |=> imem_addr_o == $past(imem_addr_o) + XLEN'(4));
  assert_one_port_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(imem_req_o && dmem_req_o));
  assert_dmem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_req_o && !dmem_rdy_i |=> dmem_req_o && $stable(dmem_addr_o)
      && $stable(dmem_we_o) && $stable(dmem_wdata_o));
  assert_retire_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
  assert_retire_cls_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |-> retire_cls_o != 2'b11);
endmodule

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req, imem_rdy, dmem_req, dmem_we, dmem_rdy, retire;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic [1:0]  retire_cls;

  always #4 clk = ~clk; // 125 MHz

  mc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_req_o(imem_req), .imem_addr_o(imem_addr), .imem_rdy_i(imem_rdy),
    .imem_rdata_i(imem_rdata),
    .dmem_req_o(dmem_req), .dmem_we_o(dmem_we), .dmem_addr_o(dmem_addr),
    .dmem_wdata_o(dmem_wdata), .dmem_rdy_i(dmem_rdy), .dmem_rdata_i(dmem_rdata),
    .retire_o(retire), .retire_cls_o(retire_cls)
  );

  localparam int NPROG = 17;
  localparam logic [31:0] PROG [NPROG] = '{
    32'h3C011234, // 0  lui r1,0x1234
    32'h8C020100, // 4  lw  r2,0x100(r0)
    32'h8C030104, // 8  lw  r3,0x104(r0)
    32'h00432020, // 12 add r4,r2,r3
    32'h00430020, // 16 add r0,r2,r3
    32'hAC040200, // 20 sw  r4,0x200(r0)
    32'hAC010204, // 24 sw  r1,0x204(r0)
    32'hAC000208, // 28 sw  r0,0x208(r0)
    32'h10430002, // 32 beq r2,r3,+2 (not taken)
    32'h14430001, // 36 bne r2,r3,+1 (taken -> 44)
    32'hAC02020C, // 40 skipped
    32'h10840001, // 44 beq r4,r4,+1 (taken -> 52)
    32'hAC020210, // 48 skipped
    32'h8C070108, // 52 lw  r7,0x108(r0)
    32'h8CE5FFFC, // 56 lw  r5,-4(r7)
    32'hAC050214, // 60 sw  r5,0x214(r0)
    32'h1000FFFF  // 64 beq r0,r0,-1 (self loop)
  };

  // expected execution trace: {fetch pc, retire class}
  localparam int NTR = 16;
  localparam logic [33:0] TRACE [NTR] = '{
    {32'd0,  2'b00}, {32'd4,  2'b01}, {32'd8,  2'b01}, {32'd12, 2'b00},
    {32'd16, 2'b00}, {32'd20, 2'b10}, {32'd24, 2'b10}, {32'd28, 2'b10},
    {32'd32, 2'b00}, {32'd36, 2'b00}, {32'd44, 2'b00}, {32'd52, 2'b01},
    {32'd56, 2'b01}, {32'd60, 2'b10}, {32'd64, 2'b00}, {32'd64, 2'b00}
  };

  logic [31:0] imem [32];
  logic [31:0] dmem [256];
  logic [31:0] fetch_log [32];
  logic [1:0]  cls_log [32];
  int fetch_n = 0, ret_n = 0, icnt = 0, dcnt = 0;
  int checks = 0, errors = 0;

  // memory responders with address-dependent wait states
  always @(negedge clk) begin
    if (!rst_n) begin
      imem_rdy = 1'b0; dmem_rdy = 1'b0; icnt = 0; dcnt = 0;
    end else begin
      if (imem_req && !imem_rdy) begin
        if (icnt >= int'((imem_addr >> 2) % 3)) begin
          imem_rdy   = 1'b1;
          imem_rdata = imem[imem_addr[6:2]];
          if (fetch_n < 32) fetch_log[fetch_n] = imem_addr;
          fetch_n++;
          icnt = 0;
        end else icnt++;
      end else imem_rdy = 1'b0;
      if (dmem_req && !dmem_rdy) begin
        if (dcnt >= int'(((dmem_addr >> 2) + 1) % 4)) begin
          dmem_rdy   = 1'b1;
          dmem_rdata = dmem[dmem_addr[9:2]];
          if (dmem_we) dmem[dmem_addr[9:2]] = dmem_wdata;
          dcnt = 0;
        end else dcnt++;
      end else dmem_rdy = 1'b0;
      if (retire) begin
        if (ret_n < 32) cls_log[ret_n] = retire_cls;
        ret_n++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  initial begin
    imem_rdy = 1'b0; dmem_rdy = 1'b0; imem_rdata = '0; dmem_rdata = '0;
    for (int i = 0; i < 32; i++) imem[i] = (i < NPROG) ? PROG[i] : 32'h0;
    for (int i = 0; i < 256; i++) dmem[i] = 32'h0;
    dmem[32'h100 >> 2] = 32'd5;
    dmem[32'h104 >> 2] = 32'd7;
    dmem[32'h108 >> 2] = 32'h10C;
    dmem[32'h208 >> 2] = 32'hFFFFFFFF;
    dmem[32'h20C >> 2] = 32'hDEADBEEF;
    dmem[32'h210 >> 2] = 32'h0000AAAA;

    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 fetch req", {31'd0, imem_req}, 32'd1);
    check("R1 fetch addr", imem_addr, 32'd0);
    check("R1 data idle", {31'd0, dmem_req}, 32'd0);
    check("R1 retire low", {31'd0, retire}, 32'd0);
    rst_n = 1'b1;

    begin : run
      int cyc = 0;
      while (ret_n < NTR && cyc < 5000) begin
        @(negedge clk);
        cyc++;
      end
      if (ret_n < NTR) begin
        errors++; checks++;
        $display("FAIL watchdog: actual %0d retirements expected %0d", ret_n, NTR);
      end
    end

    // R2/R6/R10: fetch order and retire classes against the trace
    for (int i = 0; i < NTR; i++) begin
      check("R2 R6 fetch pc", fetch_log[i], TRACE[i][33:2]);
      check("R10 retire class", {30'd0, cls_log[i]}, {30'd0, TRACE[i][1:0]});
    end

    check("R5 add r4=r2+r3 (R3 loads)", dmem[32'h200 >> 2], 32'd12);
    check("R7 lui r1",                  dmem[32'h204 >> 2], 32'h12340000);
    check("R8 r0 reads zero after write", dmem[32'h208 >> 2], 32'h0);
    check("R6 bne skipped store",       dmem[32'h20C >> 2], 32'hDEADBEEF);
    check("R6 beq skipped store",       dmem[32'h210 >> 2], 32'h0000AAAA);
    check("R3 negative offset load",    dmem[32'h214 >> 2], 32'h10C);
    check("R4 store leaves source",     dmem[32'h100 >> 2], 32'd5);
    // R9: core is parked in the self loop, so no data request is pending
    check("R9 data port idle in loop",  {31'd0, dmem_req}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule